// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block sits in the fetch stage and supplies the next fetch address one cycle after it is given a fetch PC. It holds a direct-mapped table of 2^IDX_W entries, indexed by the word-address bits of the PC. Each entry stores a valid flag, the complete PC of a control-transfer instruction as its tag, the target that instruction last jumped to, and a 2-bit saturating direction counter. A fetch PC that matches a valid entry whose counter leans taken is steered to the stored target. Every other fetch PC is steered to the sequential address PC+4.

When a branch resolves in execute, the resolve port gives its PC, its outcome, its real target and whether it is a control transfer at all. The block works out what it would predict for that PC and compares this with the real next address. On a difference it raises a one-cycle redirect carrying the correct address, and it then trains the entry. Instructions that are not control transfers never enter the table, and because the tag is the full PC they can never hit an entry either.

Top module: `btb_predictor`

## Requirements
- R1: While reset is high and in the first cycle after it, `redirect` is low and `pred_next_pc` is zero. After reset every entry is invalid, so any fetch PC is predicted as PC+4.
- R2: A fetch PC that does not equal the stored tag of a valid entry at index PC[IDX_W+1:2] yields PC+4. This includes a PC that shares the index with a stored branch but differs from it in any other bit.
- R3: A fetch PC that hits an entry yields the stored target when counter bit 1 is set (counter 2 or 3). It yields PC+4 when counter bit 1 is clear (counter 0 or 1).
- R4: A resolve with `rslv_ctrl` low raises no redirect and changes no entry.
- R5: A taken control instruction that misses allocates its entry with the resolved target and counter 2 (weakly taken). A not-taken control instruction that misses allocates nothing and raises no redirect.
- R6: For a control instruction, `redirect` is high one cycle after the resolve exactly when the real next address (the target if taken, else PC+4) differs from the prediction for that PC. `redirect_pc` then carries the real next address.
- R7: The counter moves up by one when the branch is taken and down by one when it is not, and it saturates at 3 and at 0. The predicted direction therefore flips only after two mispredictions in a row from a strong state.
- R8: A hit that was predicted correctly updates only the counter. A hit that was taken to a different target also rewrites the stored target.
- R9: When a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before the update.
- R10: `pred_next_pc` is registered: it answers the fetch PC presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | PC being fetched this cycle |
| rslv_valid | input | 1 | Resolve port carries an instruction |
| rslv_pc | input | PC_W | PC of the resolved instruction |
| rslv_taken | input | 1 | Resolved direction, 1 = taken |
| rslv_target | input | PC_W | Real target of the resolved instruction |
| rslv_ctrl | input | 1 | Resolved instruction is a control transfer |
| pred_next_pc | output | PC_W | Predicted next PC for the previous cycle's fetch PC |
| redirect | output | 1 | Previous cycle's resolve was mispredicted |
| redirect_pc | output | PC_W | Correct next PC when `redirect` is high |

## Verification
A fetch lookup and a resolve update can land on the same table entry in the same clock. This is the case that decides whether fetch sees stale or fresh contents. The bench provokes it on purpose, by allocating a branch while fetching that same PC, and it also produces it incidentally in a long pseudo-random phase over a few aliased indices. In every cycle a reference table inside the bench supplies the prediction from the contents before that cycle's update, and the bench applies the update only after it has compared both outputs.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;
  typedef logic [1:0] dir_ctr_t;

  localparam dir_ctr_t CTR_WEAK_TAKEN = 2'b10;

  // saturating step of the two-bit direction counter
  function automatic dir_ctr_t ctr_step(input dir_ctr_t c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'd1;
    else       return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/btb_table.sv
`timescale 1ns/1ps
module btb_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    ra_idx,
  output logic                ra_valid,
  output logic [PC_W-1:0]     ra_tag,
  output logic [PC_W-1:0]     ra_tgt,
  output btb_pkg::dir_ctr_t   ra_ctr,
  input  logic [IDX_W-1:0]    rb_idx,
  output logic                rb_valid,
  output logic [PC_W-1:0]     rb_tag,
  output btb_pkg::dir_ctr_t   rb_ctr,
  input  logic                wr_alloc,
  input  logic                wr_tgt_en,
  input  logic                wr_ctr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [PC_W-1:0]     wr_tag,
  input  logic [PC_W-1:0]     wr_tgt,
  input  btb_pkg::dir_ctr_t   wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [PC_W-1:0]   tag_mem [DEPTH];
  logic [PC_W-1:0]   tgt_mem [DEPTH];
  btb_pkg::dir_ctr_t ctr_mem [DEPTH];

  // only the valid flags need a reset; the payload arrays stay RAM-like
  always_ff @(posedge clk) begin
    if (rst)           valid_q         <= '0;
    else if (wr_alloc) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_alloc)              tag_mem[wr_idx] <= wr_tag;
    if (wr_alloc || wr_tgt_en) tgt_mem[wr_idx] <= wr_tgt;
    if (wr_alloc || wr_ctr_en) ctr_mem[wr_idx] <= wr_ctr;
  end

  assign ra_valid = valid_q[ra_idx];
  assign ra_tag   = tag_mem[ra_idx];
  assign ra_tgt   = tgt_mem[ra_idx];
  assign ra_ctr   = ctr_mem[ra_idx];
  assign rb_valid = valid_q[rb_idx];
  assign rb_tag   = tag_mem[rb_idx];
  assign rb_ctr   = ctr_mem[rb_idx];
endmodule

// File: rtl/btb_lookup.sv
`timescale 1ns/1ps
module btb_lookup #(
  parameter int PC_W = 32
) (
  input  logic              [PC_W-1:0] pc,
  input  logic                         e_valid,
  input  logic              [PC_W-1:0] e_tag,
  input  logic              [PC_W-1:0] e_tgt,
  input  btb_pkg::dir_ctr_t            e_ctr,
  output logic              [PC_W-1:0] next_pc
);
  localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(4);

  logic go_target;

  always_comb begin
    go_target = e_valid && (e_tag == pc) && e_ctr[1];
    next_pc   = go_target ? e_tgt : pc + SEQ_STEP;
  end
endmodule

// File: rtl/btb_resolve.sv
`timescale 1ns/1ps
module btb_resolve #(
  parameter int PC_W = 32
) (
  input  logic              [PC_W-1:0] rs_pc,
  input  logic                         rs_valid,
  input  logic                         rs_taken,
  input  logic              [PC_W-1:0] rs_target,
  input  logic                         rs_ctrl,
  input  logic                         e_valid,
  input  logic              [PC_W-1:0] e_tag,
  input  btb_pkg::dir_ctr_t            e_ctr,
  input  logic              [PC_W-1:0] pred_next,
  output logic                         mispredict,
  output logic              [PC_W-1:0] actual_next,
  output logic                         wr_alloc,
  output logic                         wr_tgt_en,
  output logic                         wr_ctr_en,
  output logic              [PC_W-1:0] wr_tag,
  output logic              [PC_W-1:0] wr_tgt,
  output btb_pkg::dir_ctr_t            wr_ctr
);
  localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(4);

  logic hit, train;

  always_comb begin
    train       = rs_valid && rs_ctrl;
    hit         = e_valid && (e_tag == rs_pc);
    actual_next = rs_taken ? rs_target : rs_pc + SEQ_STEP;
    mispredict  = train && (actual_next != pred_next);
    wr_alloc    = train && !hit && rs_taken;
    wr_ctr_en   = train && hit;
    wr_tgt_en   = train && hit && mispredict && rs_taken;
    wr_ctr      = hit ? btb_pkg::ctr_step(e_ctr, rs_taken) : btb_pkg::CTR_WEAK_TAKEN;
    wr_tag      = rs_pc;
    wr_tgt      = rs_target;
  end
endmodule

// File: rtl/btb_predictor.sv
`timescale 1ns/1ps
module btb_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            rslv_valid,
  input  logic [PC_W-1:0] rslv_pc,
  input  logic            rslv_taken,
  input  logic [PC_W-1:0] rslv_target,
  input  logic            rslv_ctrl,
  output logic [PC_W-1:0] pred_next_pc,
  output logic            redirect,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0]  f_idx, r_idx, wr_idx;
  logic              fa_valid, rb_valid;
  logic [PC_W-1:0]   fa_tag, fa_tgt, rb_tag;
  btb_pkg::dir_ctr_t fa_ctr, rb_ctr;
  logic [PC_W-1:0]   f_next, r_pred, r_actual;
  logic              r_mis, wr_alloc, wr_tgt_en, wr_ctr_en;
  logic [PC_W-1:0]   wr_tag, wr_tgt;
  btb_pkg::dir_ctr_t wr_ctr;

  assign f_idx  = fetch_pc[IDX_HI:IDX_LO];
  assign r_idx  = rslv_pc[IDX_HI:IDX_LO];
  assign wr_idx = r_idx;

  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .ra_idx(f_idx), .ra_valid(fa_valid), .ra_tag(fa_tag), .ra_tgt(fa_tgt), .ra_ctr(fa_ctr),
    .rb_idx(r_idx), .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_ctr(rb_ctr),
    .wr_alloc(wr_alloc), .wr_tgt_en(wr_tgt_en), .wr_ctr_en(wr_ctr_en),
    .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  // fetch-side prediction
  btb_lookup #(.PC_W(PC_W)) u_fetch_lkp (
    .pc(fetch_pc), .e_valid(fa_valid), .e_tag(fa_tag), .e_tgt(fa_tgt),
    .e_ctr(fa_ctr), .next_pc(f_next)
  );

  // what the table currently predicts for the resolving PC
  logic [PC_W-1:0] rb_tgt;
  assign rb_tgt = u_table.tgt_mem[r_idx];

  btb_lookup #(.PC_W(PC_W)) u_rslv_lkp (
    .pc(rslv_pc), .e_valid(rb_valid), .e_tag(rb_tag), .e_tgt(rb_tgt),
    .e_ctr(rb_ctr), .next_pc(r_pred)
  );

  btb_resolve #(.PC_W(PC_W)) u_resolve (
    .rs_pc(rslv_pc), .rs_valid(rslv_valid), .rs_taken(rslv_taken),
    .rs_target(rslv_target), .rs_ctrl(rslv_ctrl),
    .e_valid(rb_valid), .e_tag(rb_tag), .e_ctr(rb_ctr), .pred_next(r_pred),
    .mispredict(r_mis), .actual_next(r_actual),
    .wr_alloc(wr_alloc), .wr_tgt_en(wr_tgt_en), .wr_ctr_en(wr_ctr_en),
    .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  // every output leaves from a flop
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_next_pc <= '0;
      redirect     <= 1'b0;
      redirect_pc  <= '0;
    end else begin
      pred_next_pc <= f_next;
      redirect     <= r_mis;
      redirect_pc  <= r_actual;
    end
  end
endmodule

// File: rtl/btb_checker.sv
`timescale 1ns/1ps
module btb_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            rslv_valid,
  input logic [PC_W-1:0] rslv_pc,
  input logic            rslv_taken,
  input logic [PC_W-1:0] rslv_target,
  input logic            rslv_ctrl,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            redirect,
  input logic [PC_W-1:0] redirect_pc
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!redirect && pred_next_pc == '0));

  // R4
  nonctrl_no_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rslv_valid && !rslv_ctrl) |-> !redirect);

  // R6
  redirect_source_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> $past(rslv_valid && rslv_ctrl));

  // R6
  redirect_addr_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (redirect_pc == ($past(rslv_taken) ? $past(rslv_target)
                                                    : $past(rslv_pc) + PC_W'(4))));
endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .rslv_valid(rslv_valid), .rslv_pc(rslv_pc),
  .rslv_taken(rslv_taken), .rslv_target(rslv_target), .rslv_ctrl(rslv_ctrl),
  .pred_next_pc(pred_next_pc), .redirect(redirect), .redirect_pc(redirect_pc)
);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;
  localparam int PC_W  = 32;
  localparam int IDX_W = 7;
  localparam int DEPTH = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            rslv_valid = 1'b0;
  logic [PC_W-1:0] rslv_pc = '0;
  logic            rslv_taken = 1'b0;
  logic [PC_W-1:0] rslv_target = '0;
  logic            rslv_ctrl = 1'b0;
  logic [PC_W-1:0] pred_next_pc;
  logic            redirect;
  logic [PC_W-1:0] redirect_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .rslv_valid(rslv_valid), .rslv_pc(rslv_pc), .rslv_taken(rslv_taken),
    .rslv_target(rslv_target), .rslv_ctrl(rslv_ctrl),
    .pred_next_pc(pred_next_pc), .redirect(redirect), .redirect_pc(redirect_pc)
  );

  // reference table built from the requirements
  logic            m_valid [DEPTH];
  logic [PC_W-1:0] m_tag   [DEPTH];
  logic [PC_W-1:0] m_tgt   [DEPTH];
  logic [1:0]      m_ctr   [DEPTH];

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic [PC_W-1:0] model_next(input logic [PC_W-1:0] pc);
    int i = idx_of(pc);
    if (m_valid[i] && m_tag[i] == pc && m_ctr[i] >= 2'd2) return m_tgt[i];
    return pc + 32'd4;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [PC_W-1:0] got, input logic [PC_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one clock: drive at the falling edge, compare after the rising edge
  task automatic step(input string tag, input logic [PC_W-1:0] fpc,
                      input logic rv, input logic [PC_W-1:0] rpc, input logic rtk,
                      input logic [PC_W-1:0] rtgt, input logic rctl);
    logic [PC_W-1:0] e_next, e_pred, e_act;
    logic e_red, hit;
    int ri;
    e_next = model_next(fpc);
    e_pred = model_next(rpc);
    e_act  = rtk ? rtgt : rpc + 32'd4;
    e_red  = rv && rctl && (e_act != e_pred);
    @(negedge clk);
    fetch_pc = fpc; rslv_valid = rv; rslv_pc = rpc;
    rslv_taken = rtk; rslv_target = rtgt; rslv_ctrl = rctl;
    @(posedge clk); #1;
    check(tag, "pred_next_pc", pred_next_pc, e_next);
    check(tag, "redirect", {31'd0, redirect}, {31'd0, e_red});
    if (e_red) check(tag, "redirect_pc", redirect_pc, e_act);
    if (rv && rctl) begin
      ri  = idx_of(rpc);
      hit = m_valid[ri] && m_tag[ri] == rpc;
      if (hit) begin
        if (rtk) m_ctr[ri] = (m_ctr[ri] == 2'd3) ? 2'd3 : m_ctr[ri] + 2'd1;
        else     m_ctr[ri] = (m_ctr[ri] == 2'd0) ? 2'd0 : m_ctr[ri] - 2'd1;
        if (e_red && rtk) m_tgt[ri] = rtgt;
      end else if (rtk) begin
        m_valid[ri] = 1'b1; m_tag[ri] = rpc; m_tgt[ri] = rtgt; m_ctr[ri] = 2'd2;
      end
    end
  endtask

  task automatic look(input string tag, input logic [PC_W-1:0] fpc);
    step(tag, fpc, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic rslv(input string tag, input logic [PC_W-1:0] rpc,
                      input logic rtk, input logic [PC_W-1:0] rtgt, input logic rctl);
    step(tag, 32'h0, 1'b1, rpc, rtk, rtgt, rctl);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "redirect in reset", {31'd0, redirect}, 32'd0);
    check("R1", "pred in reset", pred_next_pc, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1", "redirect after reset", {31'd0, redirect}, 32'd0);

    // R1 R10: every index misses right after reset
    for (int i = 0; i < DEPTH; i++) look("R1", 32'h0000_3000 + 32'(i * 4));

    // R5 R6: taken miss allocates weakly taken and redirects
    rslv("R5", 32'h100, 1'b1, 32'h2000, 1'b1);
    look("R3", 32'h100);
    // R2: same index, different tag
    look("R2", 32'h100 + 32'h200);
    // R8: correct taken prediction, counter 2 -> 3
    rslv("R8", 32'h100, 1'b1, 32'h2000, 1'b1);
    // R7: one not-taken from strong keeps direction
    rslv("R7", 32'h100, 1'b0, 32'h0, 1'b1);
    look("R7", 32'h100);
    rslv("R7", 32'h100, 1'b0, 32'h0, 1'b1);
    look("R7", 32'h100);
    rslv("R7", 32'h100, 1'b0, 32'h0, 1'b1);
    rslv("R7", 32'h100, 1'b0, 32'h0, 1'b1);
    rslv("R7", 32'h100, 1'b1, 32'h2000, 1'b1);
    look("R7", 32'h100);
    rslv("R7", 32'h100, 1'b1, 32'h2000, 1'b1);
    look("R3", 32'h100);
    // R8: taken to a new target rewrites it
    rslv("R8", 32'h100, 1'b1, 32'h3000, 1'b1);
    look("R8", 32'h100);
    // R5: not-taken miss allocates nothing
    rslv("R5", 32'h400, 1'b0, 32'h0, 1'b1);
    look("R5", 32'h400);
    // R4: non-control resolve is ignored
    rslv("R4", 32'h100, 1'b1, 32'h5000, 1'b0);
    rslv("R4", 32'h700, 1'b1, 32'h5000, 1'b0);
    look("R4", 32'h100);
    look("R4", 32'h700);
    // R9: same-cycle lookup and allocation of one entry
    step("R9", 32'h600, 1'b1, 32'h600, 1'b1, 32'h9000, 1'b1);
    look("R9", 32'h600);

    // R5 R3: allocate every index, looking up the previous one alongside
    for (int i = 0; i < DEPTH; i++)
      step("R5", 32'h1_0000 + 32'((i - 1) * 4), 1'b1, 32'h1_0000 + 32'(i * 4),
           1'b1, 32'h2_0000 + 32'(i * 8), 1'b1);
    for (int i = 0; i < DEPTH; i++) look("R3", 32'h1_0000 + 32'(i * 4));

    // R2 R6 R7 R9: pseudo-random traffic over aliased PCs
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] fp, rp;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rp = 32'h8000 + {25'd0, lfsr[4:0], 2'b00} + {21'd0, lfsr[6:5], 9'd0};
      fp = 32'h8000 + {25'd0, lfsr[20:16], 2'b00} + {21'd0, lfsr[22:21], 9'd0};
      step("R6", fp, lfsr[23], rp, lfsr[7],
           32'h4000 + {24'd0, lfsr[15:10], 2'b00}, lfsr[9:8] != 2'b00);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule